// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads two entries from page tables held in memory. The top ten address bits select an entry in a page directory, and the directory's location comes from a base register. That entry names a page table. The next ten bits select an entry in that table. The table entry gives a 4 KB frame, and the low twelve bits of the request are appended to the frame number unchanged.

A client presents an address while the walker is idle. The walker then issues a read for the directory entry and waits for the memory to answer. If that entry is present, it issues a read for the table entry. After the second answer it raises a one-cycle completion pulse. The pulse carries either the physical address or a fault that says which level was missing. Only one walk is handled at a time. The directory base can be changed only between walks.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_req` and `done_valid` are 0, and the directory base is zero, so the first read of a walk goes to address `vaddr[31:22]*4`. A reset during a walk abandons that walk.
- R2: The first read of every walk is at address `base + vaddr[31:22]*4`.
- R3: When the directory entry is present, the second read is at `{pde[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: When both entries are present, the completion reports `done_fault`=0 and `done_paddr` = `{pte[31:12], vaddr[11:0]}`.
- R5: When bit 0 of the directory entry is 0, the walk completes after one read with `done_fault`=1, `done_fault_lvl`=0 and `done_paddr`=0. No second read is issued.
- R6: When bit 0 of the table entry is 0, the walk completes after two reads with `done_fault`=1, `done_fault_lvl`=1 and `done_paddr`=0.
- R7: Each read holds `mem_req`=1 with a stable `mem_addr` until a cycle in which `mem_rsp_valid` is 1. A `mem_rsp_valid` that arrives while no read is outstanding has no effect.
- R8: A request is taken only when `req_ready` is 1. `req_ready` stays 0 from acceptance until the cycle after the completion pulse, and `req_valid` raised in that interval is ignored.
- R9: Each accepted request yields exactly one `done_valid` pulse, which lasts one cycle.
- R10: A write to the directory base takes effect only while the walker is idle. A write made during a walk is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Write strobe for the directory base |
| base_wr_data | input | 32 | New directory base address |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle; a request is accepted this cycle |
| mem_req | output | 1 | Memory read outstanding |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid this cycle |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address, or zero on a fault |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_fault_lvl | output | 1 | Faulting level: 0 directory, 1 table |

## Verification
The hardest situations to reach are the ones where something happens while a walk is still waiting on memory: a base write, a second request, or a reset. The bench's memory model stretches its response latency to several cycles. It fires those events while `mem_req` is held, then checks that the result and the addresses of the next walk are unaffected. A response pulse injected while no read is outstanding covers the stray-response case. A table of translations covers both fault levels and the extreme index values 0 and 1023.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_DIR  = 2'd1,
      WS_TBL  = 2'd2,
      WS_DONE = 2'd3
   } walk_state_t;

   localparam logic LVL_DIR = 1'b0;
   localparam logic LVL_TBL = 1'b1;
endpackage

// File: rtl/pgwalk_base_reg.sv
module pgwalk_base_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              wr_allow,
   output logic [ADDR_W-1:0] base
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base <= '0;
      end else if (wr_en && wr_allow) begin
         base <= wr_data;
      end
   end
endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
   parameter int ADDR_W      = 32,
   parameter int DIR_W       = 10,
   parameter int TBL_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [ADDR_W-1:0]       base,
   input  logic [DIR_W-1:0]        dir_idx,
   input  logic [TBL_W-1:0]        tbl_idx,
   input  logic [ADDR_W-OFF_W-1:0] pde_frame,
   input  logic                    sel_tbl,
   output logic [ADDR_W-1:0]       mem_addr
);
   localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
   localparam bit ENTRY_POW2  = ((ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0);

   logic [ADDR_W-1:0] dir_off;
   logic [ADDR_W-1:0] tbl_off;
   logic [ADDR_W-1:0] tbl_base;

   generate
      if (ENTRY_POW2) begin : g_shift
         assign dir_off = ADDR_W'(dir_idx) << ENTRY_SHIFT;
         assign tbl_off = ADDR_W'(tbl_idx) << ENTRY_SHIFT;
      end else begin : g_mult
         assign dir_off = ADDR_W'(dir_idx) * ADDR_W'(ENTRY_BYTES);
         assign tbl_off = ADDR_W'(tbl_idx) * ADDR_W'(ENTRY_BYTES);
      end
   endgenerate

   assign tbl_base = {pde_frame, {OFF_W{1'b0}}};

   always_comb begin
      if (sel_tbl) begin
         mem_addr = tbl_base + tbl_off;
      end else begin
         mem_addr = base + dir_off;
      end
   end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DIR_W  = 10,
   parameter int TBL_W  = 10,
   parameter int OFF_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [ADDR_W-1:0]       req_vaddr,
   output logic                    req_ready,
   input  logic                    rsp_valid,
   input  logic                    rsp_present,
   input  logic [ADDR_W-OFF_W-1:0] rsp_frame,
   output logic                    mem_req,
   output logic                    sel_tbl,
   output logic [DIR_W-1:0]        dir_idx,
   output logic [TBL_W-1:0]        tbl_idx,
   output logic [ADDR_W-OFF_W-1:0] pde_frame,
   output logic                    done_valid,
   output logic [ADDR_W-1:0]       done_paddr,
   output logic                    done_fault,
   output logic                    done_fault_lvl,
   output walk_state_t             state
);
   localparam int FRAME_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0]  vaddr_q;
   logic [FRAME_W-1:0] frame_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state          <= WS_IDLE;
         vaddr_q        <= '0;
         frame_q        <= '0;
         done_paddr     <= '0;
         done_fault     <= 1'b0;
         done_fault_lvl <= LVL_DIR;
      end else begin
         case (state)
            WS_IDLE: begin
               if (req_valid) begin
                  vaddr_q        <= req_vaddr;
                  done_paddr     <= '0;
                  done_fault     <= 1'b0;
                  done_fault_lvl <= LVL_DIR;
                  state          <= WS_DIR;
               end
            end
            WS_DIR: begin
               if (rsp_valid) begin
                  if (!rsp_present) begin
                     done_fault     <= 1'b1;
                     done_fault_lvl <= LVL_DIR;
                     done_paddr     <= '0;
                     state          <= WS_DONE;
                  end else begin
                     frame_q <= rsp_frame;
                     state   <= WS_TBL;
                  end
               end
            end
            WS_TBL: begin
               if (rsp_valid) begin
                  if (!rsp_present) begin
                     done_fault     <= 1'b1;
                     done_fault_lvl <= LVL_TBL;
                     done_paddr     <= '0;
                  end else begin
                     done_fault     <= 1'b0;
                     done_fault_lvl <= LVL_DIR;
                     done_paddr     <= {rsp_frame, vaddr_q[OFF_W-1:0]};
                  end
                  state <= WS_DONE;
               end
            end
            default: begin
               state <= WS_IDLE;
            end
         endcase
      end
   end

   assign req_ready  = (state == WS_IDLE);
   assign mem_req    = (state == WS_DIR) || (state == WS_TBL);
   assign sel_tbl    = (state == WS_TBL);
   assign done_valid = (state == WS_DONE);
   assign dir_idx    = vaddr_q[ADDR_W-1 -: DIR_W];
   assign tbl_idx    = vaddr_q[OFF_W +: TBL_W];
   assign pde_frame  = frame_q;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DIR_W       = 10,
   parameter int TBL_W       = 10,
   parameter int OFF_W       = 12,
   parameter int ENTRY_W     = 32,
   parameter int ENTRY_BYTES = 4,
   parameter int PRESENT_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_wr_en,
   input  logic [ADDR_W-1:0] base_wr_data,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_vaddr,
   output logic              req_ready,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic              done_valid,
   output logic [ADDR_W-1:0] done_paddr,
   output logic              done_fault,
   output logic              done_fault_lvl
);
   localparam int FRAME_W = ADDR_W - OFF_W;

   generate
      if (ADDR_W != DIR_W + TBL_W + OFF_W) begin : g_bad_split
         $error("pgwalk_top: index and offset widths must sum to ADDR_W");
      end
      if (ENTRY_W < FRAME_W) begin : g_bad_entry
         $error("pgwalk_top: entry too narrow to hold a frame number");
      end
      if (PRESENT_BIT >= ENTRY_W - FRAME_W) begin : g_bad_present
         $error("pgwalk_top: present flag overlaps the frame field");
      end
   endgenerate

   logic [ADDR_W-1:0]  base_q;
   logic [DIR_W-1:0]   dir_idx;
   logic [TBL_W-1:0]   tbl_idx;
   logic [FRAME_W-1:0] pde_frame;
   logic               sel_tbl;
   logic               rsp_present;
   logic [FRAME_W-1:0] rsp_frame;
   walk_state_t        walk_state;
   logic               unused_rsp;

   assign rsp_present = mem_rsp_data[PRESENT_BIT];
   assign rsp_frame   = mem_rsp_data[ENTRY_W-1 -: FRAME_W];
   assign unused_rsp  = ^mem_rsp_data;

   pgwalk_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (base_wr_en),
      .wr_data  (base_wr_data),
      .wr_allow (req_ready),
      .base     (base_q)
   );

   pgwalk_ctrl #(
      .ADDR_W (ADDR_W),
      .DIR_W  (DIR_W),
      .TBL_W  (TBL_W),
      .OFF_W  (OFF_W)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_vaddr      (req_vaddr),
      .req_ready      (req_ready),
      .rsp_valid      (mem_rsp_valid),
      .rsp_present    (rsp_present),
      .rsp_frame      (rsp_frame),
      .mem_req        (mem_req),
      .sel_tbl        (sel_tbl),
      .dir_idx        (dir_idx),
      .tbl_idx        (tbl_idx),
      .pde_frame      (pde_frame),
      .done_valid     (done_valid),
      .done_paddr     (done_paddr),
      .done_fault     (done_fault),
      .done_fault_lvl (done_fault_lvl),
      .state          (walk_state)
   );

   pgwalk_addr_gen #(
      .ADDR_W      (ADDR_W),
      .DIR_W       (DIR_W),
      .TBL_W       (TBL_W),
      .OFF_W       (OFF_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_agen (
      .base      (base_q),
      .dir_idx   (dir_idx),
      .tbl_idx   (tbl_idx),
      .pde_frame (pde_frame),
      .sel_tbl   (sel_tbl),
      .mem_addr  (mem_addr)
   );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
   import pgwalk_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFF_W   = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic                    mem_req,
   input logic [ADDR_W-1:0]       mem_addr,
   input logic                    mem_rsp_valid,
   input logic                    rsp_present,
   input logic [ADDR_W-OFF_W-1:0] rsp_frame,
   input logic                    done_valid,
   input logic [ADDR_W-1:0]       done_paddr,
   input logic                    done_fault,
   input logic                    done_fault_lvl,
   input walk_state_t             st,
   input logic [ADDR_W-1:0]       base
);
   p_hold_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_req && !req_ready));

   p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || done_valid) |-> !req_ready);

   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> (!done_valid && req_ready));

   p_dir_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_DIR && mem_rsp_valid && !rsp_present)
      |=> (done_valid && done_fault && done_fault_lvl == LVL_DIR));

   p_tbl_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_TBL && mem_rsp_valid && !rsp_present)
      |=> (done_valid && done_fault && done_fault_lvl == LVL_TBL));

   p_fault_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fault) |-> (done_paddr == '0));

   p_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WS_TBL && mem_rsp_valid && rsp_present)
      |=> (done_valid && !done_fault
           && done_paddr[ADDR_W-1:OFF_W] == $past(rsp_frame)));

   p_base_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> $stable(base));
endmodule

bind pgwalk_top pgwalk_chk #(
   .ADDR_W (ADDR_W),
   .OFF_W  (OFF_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .mem_req        (mem_req),
   .mem_addr       (mem_addr),
   .mem_rsp_valid  (mem_rsp_valid),
   .rsp_present    (rsp_present),
   .rsp_frame      (rsp_frame),
   .done_valid     (done_valid),
   .done_paddr     (done_paddr),
   .done_fault     (done_fault),
   .done_fault_lvl (done_fault_lvl),
   .st             (walk_state),
   .base           (base_q)
);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_wr_en = 1'b0;
   logic [31:0] base_wr_data = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done_valid;
   logic [31:0] done_paddr;
   logic        done_fault;
   logic        done_fault_lvl;

   always #2 clk = ~clk;

   pgwalk_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done_valid(done_valid), .done_paddr(done_paddr),
      .done_fault(done_fault), .done_fault_lvl(done_fault_lvl)
   );

   int total = 0;
   int bad = 0;
   int lat = 0;
   int wait_cnt = 0;
   int rd_cnt = 0;
   int cycles = 0;
   logic stray = 1'b0;
   logic [31:0] rd_log [4];
   logic [31:0] mem [logic [31:0]];

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   // memory model: answers after lat idle cycles, logs every read address
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rsp_valid = 1'b0;
         wait_cnt = 0;
      end else if (mem_rsp_valid) begin
         mem_rsp_valid = 1'b0;
         wait_cnt = 0;
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data = rd(mem_addr);
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
            rd_cnt++;
         end else begin
            wait_cnt++;
         end
      end else if (stray) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data = 32'hFFFF_F001;
         stray = 1'b0;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog act=%0d exp=<100000 cycles", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic start_walk(input logic [31:0] va);
      @(negedge clk);
      rd_cnt = 0;
      req_valid = 1'b1;
      req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      while (!done_valid) @(negedge clk);
   endtask

   localparam logic [31:0] BASE = 32'h0001_0000;
   localparam int NV = 6;
   localparam logic [31:0] VA [NV] = '{
      32'h0040_0ABC, 32'h007F_FFFF, 32'hFFC0_7000,
      32'h0081_2345, 32'h0040_5010, 32'h0000_0123 };
   // {fault, level, paddr}
   localparam logic [33:0] EXP [NV] = '{
      {2'b00, 32'h1234_5ABC}, {2'b00, 32'hABCD_EFFF}, {2'b00, 32'hFFFF_F000},
      {2'b10, 32'h0}, {2'b11, 32'h0}, {2'b10, 32'h0} };

   initial begin
      mem[32'h0001_0004] = 32'h0002_0001;   // dir 1 -> table 0x20000
      mem[32'h0001_0FFC] = 32'h0003_0001;   // dir 1023 -> table 0x30000
      mem[32'h0001_0008] = 32'h0004_0000;   // dir 2 not present
      mem[32'h0002_0000] = 32'h1234_5003;
      mem[32'h0002_0FFC] = 32'hABCD_E001;
      mem[32'h0002_0014] = 32'h0000_0000;
      mem[32'h0003_001C] = 32'hFFFF_F001;
      mem[32'h0005_000C] = 32'h0006_0001;   // alternate base, dir 3

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ready", 32'(req_ready), 32'h1);
      check("R1 mem_req", 32'(mem_req), 32'h0);
      check("R1 done", 32'(done_valid), 32'h0);
      start_walk(32'h00C0_0000);
      wait_done();
      check("R1 base zero", rd_log[0], 32'h0000_000C);

      // R10 base write while idle
      @(negedge clk);
      base_wr_en = 1'b1; base_wr_data = BASE;
      @(negedge clk);
      base_wr_en = 1'b0;

      // table-driven walks, R2..R6
      for (int i = 0; i < NV; i++) begin
         logic [31:0] pde_a;
         logic [31:0] pte_a;
         lat = i % 3;
         pde_a = BASE + {20'h0, VA[i][31:22], 2'b00};
         pte_a = {rd(pde_a)[31:12], 12'h0} + {20'h0, VA[i][21:12], 2'b00};
         start_walk(VA[i]);
         wait_done();
         check("R2 dir addr", rd_log[0], pde_a);
         check("R4/R5/R6 fault", 32'(done_fault), 32'(EXP[i][33]));
         if (EXP[i][33]) check("R5/R6 level", 32'(done_fault_lvl), 32'(EXP[i][32]));
         check("R4 paddr", done_paddr, EXP[i][31:0]);
         if (EXP[i][33:32] == 2'b10) begin
            check("R5 one read", 32'(rd_cnt), 32'd1);
         end else begin
            check("R3 tbl addr", rd_log[1], pte_a);
            check("R6 two reads", 32'(rd_cnt), 32'd2);
         end
         @(negedge clk);
         check("R9 single pulse", 32'(done_valid), 32'h0);
      end

      // R8 / R10: base write and new request during a slow walk
      lat = 5;
      start_walk(32'h0040_0ABC);
      check("R8 busy", 32'(req_ready), 32'h0);
      base_wr_en = 1'b1; base_wr_data = 32'h0005_0000;
      req_valid = 1'b1; req_vaddr = 32'h007F_FFFF;
      @(negedge clk);
      base_wr_en = 1'b0; req_valid = 1'b0;
      wait_done();
      check("R8 first result kept", done_paddr, 32'h1234_5ABC);
      @(negedge clk);
      check("R8 ready after done", 32'(req_ready), 32'h1);
      repeat (3) @(negedge clk);
      check("R8 no second walk", 32'(mem_req), 32'h0);
      lat = 0;
      start_walk(32'h0040_0ABC);
      wait_done();
      check("R10 busy write ignored", rd_log[0], 32'h0001_0004);

      // R7 stray response while idle
      @(negedge clk);
      stray = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R7 stray ignored done", 32'(done_valid), 32'h0);
         check("R7 stray ignored ready", 32'(req_ready), 32'h1);
      end

      // R1 reset during a walk
      lat = 8;
      start_walk(32'h0040_0ABC);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 abort ready", 32'(req_ready), 32'h1);
      check("R1 abort mem_req", 32'(mem_req), 32'h0);
      check("R1 abort done", 32'(done_valid), 32'h0);
      lat = 1;
      start_walk(32'h00C0_0000);
      wait_done();
      check("R1 base cleared", rd_log[0], 32'h0000_000C);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule